// File: doc/BRIEF.md
# Configurable Interrupt Aggregator

This block gathers a vector of internal event lines into a single host interrupt pin. Each event line passes through a synchronizer and then a per-source detector. The detector can be set to catch a rising edge, catch a falling edge, or track the level. What each detector finds is kept in a read-only status word. A host read strobe clears the latched edge bits.

A per-source mask decides which status bits may raise the interrupt. The combined request is registered before it reaches the pin. The pin can be driven in three ways:
- active-low push-pull;
- active-high push-pull;
- active-low open-drain, which drives low only while a request is pending and is otherwise released. This mode lets several peripherals share one wired-OR host line.

Configuration is loaded through whole-word write strobes. The bus protocol and the pad itself sit outside the block.

Top module: `irq_aggregator`

## Requirements
- R1: After reset, every status bit is 0, every source is masked, and the pin mode is active-low push-pull. The pin therefore shows int_out=1 and int_oe=1.
- R2: Source i takes its detection mode from bits [2i+1:2i] of the mode word. The codes are 00 = rising edge, 01 = falling edge, 10 = level, and 11 = level.
- R3: An edge-mode status bit is set by its edge and then stays set until a read. On a rising edge where stat_rd is high, the bit is cleared, unless a new edge for that source is detected in the same cycle; in that case the bit stays set.
- R4: A level-mode status bit equals the synchronized input and is never latched. A read does not change it.
- R5: A mask bit of 1 stops its source from raising the interrupt. The status bit is still recorded and readable.
- R6: The interrupt request is the OR of all status bits whose mask is 0, registered once. An input change reaches the status word on the 3rd rising clock edge after it, and reaches the pin on the 4th.
- R7: Pin mode bits [1:0] select the drive, where irq is the registered request:
  - 00 (and 11): int_out=~irq, int_oe=1;
  - 01: int_out=irq, int_oe=1;
  - 10: int_out=0, int_oe=irq.
- R8: A mode, mask or pin-mode write strobe loads the whole word on that clock edge. The new value takes effect from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| evt_in | input | N_SRC | Asynchronous event lines |
| mode_wr | input | 1 | Load strobe for the detection-mode word |
| mode_wdata | input | 2*N_SRC | Detection modes, two bits per source |
| mask_wr | input | 1 | Load strobe for the mask word |
| mask_wdata | input | N_SRC | Mask bits, 1 = blocked |
| pmode_wr | input | 1 | Load strobe for the pin mode |
| pmode_wdata | input | 2 | Pin drive mode |
| stat_rd | input | 1 | Status read strobe; clears latched edge bits |
| stat_rdata | output | N_SRC | Status word |
| int_out | output | 1 | Pin data level |
| int_oe | output | 1 | Pin output enable |

## Verification
The hardest case to reach from the ports is a read strobe that lands in exactly the cycle where a new edge is detected on a bit that is already latched. To reach it, the bench first latches the bit with a rise and then drops the line. It then raises the line again and asserts the read strobe two falling edges later. Counting through the two synchronizer flops, that places the read on the clock edge where the edge detector fires. The bench then expects the bit to survive. Every source, detection code and pin code is also swept, and the pin is checked one cycle before and at the expected change.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;

   typedef enum logic [1:0] {
      DET_RISE   = 2'b00,
      DET_FALL   = 2'b01,
      DET_LEVEL  = 2'b10,
      DET_LEVEL2 = 2'b11
   } det_mode_e;

   typedef enum logic [1:0] {
      PIN_LOW_PP  = 2'b00,
      PIN_HIGH_PP = 2'b01,
      PIN_LOW_OD  = 2'b10,
      PIN_LOW_PP2 = 2'b11
   } pin_mode_e;

   function automatic logic det_is_level(input logic [1:0] m);
      return m[1];
   endfunction

endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
   parameter int W      = 8,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   if (STAGES < 2) begin : g_bad_stages
      $error("irq_sync: STAGES must be at least 2");
   end

   logic [W-1:0] chain [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int k = 0; k < STAGES; k++) chain[k] <= '0;
      end else begin
         chain[0] <= d;
         for (int k = 1; k < STAGES; k++) chain[k] <= chain[k-1];
      end
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/irq_src_cell.sv
module irq_src_cell
   import irq_agg_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       lvl,
   input  logic [1:0] mode,
   input  logic       clr,
   output logic       hit,
   output logic       stat
);
   logic prev_q;
   logic stat_q;
   logic rise, fall;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= 1'b0;
      else        prev_q <= lvl;
   end

   assign rise = lvl & ~prev_q;
   assign fall = ~lvl & prev_q;

   always_comb begin
      unique case (det_mode_e'(mode))
         DET_RISE: hit = rise;
         DET_FALL: hit = fall;
         default:  hit = 1'b0;
      endcase
   end

   // edge bits: a fresh edge wins over a read in the same cycle
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                  stat_q <= 1'b0;
      else if (det_is_level(mode)) stat_q <= lvl;
      else                         stat_q <= (stat_q & ~clr) | hit;
   end

   assign stat = stat_q;
endmodule

// File: rtl/irq_pin_drive.sv
module irq_pin_drive
   import irq_agg_pkg::*;
#(
   parameter bit ALLOW_OD = 1'b1
) (
   input  logic       req,
   input  logic [1:0] pmode,
   output logic       pin_out,
   output logic       pin_oe
);
   if (ALLOW_OD) begin : g_full
      always_comb begin
         unique case (pin_mode_e'(pmode))
            PIN_HIGH_PP: begin pin_out = req;  pin_oe = 1'b1; end
            PIN_LOW_OD:  begin pin_out = 1'b0; pin_oe = req;  end
            default:     begin pin_out = ~req; pin_oe = 1'b1; end
         endcase
      end
   end else begin : g_push_pull_only
      always_comb begin
         pin_oe  = 1'b1;
         pin_out = (pmode == PIN_HIGH_PP) ? req : ~req;
      end
   end
endmodule

// File: rtl/irq_aggregator.sv
module irq_aggregator
   import irq_agg_pkg::*;
#(
   parameter int N_SRC       = 8,
   parameter int SYNC_STAGES = 2,
   parameter bit ALLOW_OD    = 1'b1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [N_SRC-1:0]     evt_in,
   input  logic                 mode_wr,
   input  logic [2*N_SRC-1:0]   mode_wdata,
   input  logic                 mask_wr,
   input  logic [N_SRC-1:0]     mask_wdata,
   input  logic                 pmode_wr,
   input  logic [1:0]           pmode_wdata,
   input  logic                 stat_rd,
   output logic [N_SRC-1:0]     stat_rdata,
   output logic                 int_out,
   output logic                 int_oe
);
   localparam int MODE_W = 2 * N_SRC;

   if (N_SRC < 1 || N_SRC > 64) begin : g_bad_nsrc
      $error("irq_aggregator: N_SRC must lie in 1..64");
   end

   logic [N_SRC-1:0][1:0] mode_q;
   logic [N_SRC-1:0]      mask_q;
   logic [1:0]            pmode_q;
   logic [N_SRC-1:0]      sync_lvl;
   logic [N_SRC-1:0]      edge_hit;
   logic [N_SRC-1:0]      lvl_sel;
   logic [N_SRC-1:0]      stat_vec;
   logic                  irq_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q  <= '0;
         mask_q  <= '1;
         pmode_q <= PIN_LOW_PP;
      end else begin
         if (mode_wr)  mode_q  <= mode_wdata[MODE_W-1:0];
         if (mask_wr)  mask_q  <= mask_wdata;
         if (pmode_wr) pmode_q <= pmode_wdata;
      end
   end

   irq_sync #(.W(N_SRC), .STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (evt_in),
      .q     (sync_lvl)
   );

   for (genvar i = 0; i < N_SRC; i++) begin : g_src
      assign lvl_sel[i] = det_is_level(mode_q[i]);
      irq_src_cell u_cell (
         .clk   (clk),
         .rst_n (rst_n),
         .lvl   (sync_lvl[i]),
         .mode  (mode_q[i]),
         .clr   (stat_rd),
         .hit   (edge_hit[i]),
         .stat  (stat_vec[i])
      );
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) irq_q <= 1'b0;
      else        irq_q <= |(stat_vec & ~mask_q);
   end

   irq_pin_drive #(.ALLOW_OD(ALLOW_OD)) u_pin (
      .req     (irq_q),
      .pmode   (pmode_q),
      .pin_out (int_out),
      .pin_oe  (int_oe)
   );

   assign stat_rdata = stat_vec;
endmodule

// File: rtl/irq_aggregator_chk.sv
module irq_aggregator_chk #(
   parameter int N_SRC    = 8,
   parameter bit ALLOW_OD = 1'b1
) (
   input logic             clk,
   input logic             rst_n,
   input logic             stat_rd,
   input logic             mode_wr,
   input logic [N_SRC-1:0] stat_rdata,
   input logic [N_SRC-1:0] mask_q,
   input logic [N_SRC-1:0] lvl_sel,
   input logic [N_SRC-1:0] sync_lvl,
   input logic [N_SRC-1:0] edge_hit,
   input logic             irq_q,
   input logic [1:0]       pmode_q,
   input logic             int_out,
   input logic             int_oe
);
   assert_edge_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (!stat_rd && !mode_wr) |=>
         ((stat_rdata & $past(stat_rdata & ~lvl_sel)) == $past(stat_rdata & ~lvl_sel)));

   assert_read_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_rd && !mode_wr) |=>
         ((stat_rdata & ~$past(lvl_sel) & ~$past(edge_hit)) == '0));

   assert_level_track_R4: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (((stat_rdata ^ $past(sync_lvl)) & $past(lvl_sel)) == '0));

   assert_request_R6: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (irq_q == $past(|(stat_rdata & ~mask_q))));

   assert_push_pull_oe_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (pmode_q != 2'b10 || !ALLOW_OD) |-> int_oe);

   assert_open_drain_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (pmode_q == 2'b10 && ALLOW_OD) |-> (!int_out && (int_oe == irq_q)));
endmodule

bind irq_aggregator irq_aggregator_chk #(.N_SRC(N_SRC), .ALLOW_OD(ALLOW_OD)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .stat_rd    (stat_rd),
   .mode_wr    (mode_wr),
   .stat_rdata (stat_rdata),
   .mask_q     (mask_q),
   .lvl_sel    (lvl_sel),
   .sync_lvl   (sync_lvl),
   .edge_hit   (edge_hit),
   .irq_q      (irq_q),
   .pmode_q    (pmode_q),
   .int_out    (int_out),
   .int_oe     (int_oe)
);

// File: tb/irq_aggregator_test.sv
module irq_aggregator_test;
   localparam int N        = 4;
   localparam int CLK_HALF = 5;

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic [N-1:0]   evt_in = '0;
   logic           mode_wr = 1'b0;
   logic [2*N-1:0] mode_wdata = '0;
   logic           mask_wr = 1'b0;
   logic [N-1:0]   mask_wdata = '0;
   logic           pmode_wr = 1'b0;
   logic [1:0]     pmode_wdata = '0;
   logic           stat_rd = 1'b0;
   logic [N-1:0]   stat_rdata;
   logic           int_out, int_oe;

   int n_chk = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   always #CLK_HALF clk = ~clk;

   irq_aggregator #(.N_SRC(N)) uut (
      .clk(clk), .rst_n(rst_n), .evt_in(evt_in),
      .mode_wr(mode_wr), .mode_wdata(mode_wdata),
      .mask_wr(mask_wr), .mask_wdata(mask_wdata),
      .pmode_wr(pmode_wr), .pmode_wdata(pmode_wdata),
      .stat_rd(stat_rd), .stat_rdata(stat_rdata),
      .int_out(int_out), .int_oe(int_oe)
   );

   task automatic step(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   function automatic logic [1:0] pin_exp(input int om, input logic irq);
      if (om == 1) return {irq, 1'b1};
      if (om == 2) return {1'b0, irq};
      return {~irq, 1'b1};
   endfunction

   task automatic wr_mode(input logic [2*N-1:0] v);
      mode_wdata = v; mode_wr = 1'b1; step(1); mode_wr = 1'b0;
   endtask
   task automatic wr_mask(input logic [N-1:0] v);
      mask_wdata = v; mask_wr = 1'b1; step(1); mask_wr = 1'b0;
   endtask
   task automatic wr_pmode(input logic [1:0] v);
      pmode_wdata = v; pmode_wr = 1'b1; step(1); pmode_wr = 1'b0;
   endtask
   task automatic rd_pulse();
      stat_rd = 1'b1; step(1); stat_rd = 1'b0;
   endtask

   initial begin
      // R1: reset state
      step(3);
      rst_n = 1'b1;
      step(1);
      chk("R1 status", stat_rdata, 0);
      chk("R1 pin", {int_out, int_oe}, 2'b11);

      // R5: all masked after reset; default rising mode latches
      evt_in = '1;
      step(6);
      chk("R5 status recorded", stat_rdata, 4'hF);
      chk("R5 masked pin", {int_out, int_oe}, 2'b11);
      wr_mask(4'b1110);
      step(1);
      chk("R8 mask write takes effect", {int_out, int_oe}, 2'b01);
      evt_in = '0;
      step(4);
      rd_pulse();
      wr_mask('1);
      step(3);
      chk("R3 cleared after read", stat_rdata, 0);

      // R2 R6 R7 sweep: every source, detect code, pin code
      for (int s = 0; s < N; s++) begin
         for (int m = 0; m < 4; m++) begin
            for (int om = 0; om < 4; om++) begin
               logic [2*N-1:0] mv;
               logic hit_up, hit_dn;
               mv = '0;
               mv[2*s +: 2] = m[1:0];
               wr_mode(mv);
               wr_mask(~(4'b1 << s));
               wr_pmode(om[1:0]);
               step(4);
               rd_pulse();
               step(2);
               hit_up = (m != 1);
               hit_dn = (m == 0 || m == 1);
               evt_in[s] = 1'b1;
               step(3);
               chk("R2 status after rise", stat_rdata, hit_up ? (32'd1 << s) : 32'd0);
               chk("R6 pin not yet", {int_out, int_oe}, pin_exp(om, 1'b0));
               step(1);
               chk("R7 pin after rise", {int_out, int_oe}, pin_exp(om, hit_up));
               evt_in[s] = 1'b0;
               step(4);
               chk("R2 status after fall", stat_rdata, hit_dn ? (32'd1 << s) : 32'd0);
               rd_pulse();
               chk("R3 R4 status after read", stat_rdata, 0);
               step(1);
               chk("R6 pin after read", {int_out, int_oe}, pin_exp(om, 1'b0));
            end
         end
      end

      // R3: read coincides with a fresh edge on a latched bit
      wr_mode('0);
      wr_mask(4'b1110);
      wr_pmode(2'b00);
      step(4);
      rd_pulse();
      evt_in[0] = 1'b1;
      step(4);
      evt_in[0] = 1'b0;
      step(4);
      chk("R3 latched before coincidence", stat_rdata, 1);
      evt_in[0] = 1'b1;
      step(2);
      stat_rd = 1'b1;
      step(1);
      stat_rd = 1'b0;
      chk("R3 edge beats read", stat_rdata, 1);
      step(1);
      chk("R3 pin held", {int_out, int_oe}, 2'b01);
      rd_pulse();
      chk("R3 later read clears", stat_rdata, 0);
      evt_in[0] = 1'b0;
      step(4);

      // R4: level bit ignores read
      wr_mode(8'b0000_1000);
      wr_mask(4'b1101);
      evt_in[1] = 1'b1;
      step(4);
      rd_pulse();
      chk("R4 level survives read", stat_rdata, 2);
      step(1);
      chk("R4 pin still asserted", {int_out, int_oe}, 2'b01);
      evt_in[1] = 1'b0;
      step(3);
      chk("R4 level drops", stat_rdata, 0);

      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
         $finish;
      end
   end
endmodule